// File: doc/BRIEF.md
# Indirect Coefficient and Configuration Access Controller

This block gives a processor bus access to a 256-word coefficient RAM and to a small page of configuration registers. It does so through three directly addressed registers. The first is a main control register whose bit 12 turns on hold mode. The second is a data register. The third is an indirect address register. A write to the indirect address register is what starts an access. Bit 15 of the written value chooses the direction. The remaining bits choose the target page and the word within it.

While hold mode is on, the processor owns the RAM port. While it is off, the consuming datapath owns it. In that case the datapath's read address drives the RAM, and indirect strobes do nothing.

Each accepted strobe starts a fixed lockout, shown on `busy_o`. A register write that arrives during the lockout is dropped and raises a sticky error flag. A configuration word does not take effect on its first write. A second, consecutive write strobe to the same word moves it into the active copy that drives the rest of the chip.

Top module: `coef_access_port`

## Requirements
- R1: After reset, `busy_o`, `err_o`, `hold_o`, `rd_data_o`, `dp_coef_o` and `cfg_active_o` are all zero.
- R2: A write to direct address 0x0C loads hold mode from bit 12 of the written word, and `hold_o` shows it from the next cycle.
- R3: An accepted strobe is a write to direct address 0x15 while hold mode is on and `busy_o` is low. With bit 15 = 0, and with bits 9:8 = 2'b11 and bits 14:11 = 0, it copies the data register (address 0x14) into RAM word bits 7:0.
- R4: An accepted strobe with bit 15 = 1 loads `rd_data_o` on the same edge. The source is the addressed RAM word, or the configuration shadow word for a configuration-page address, or zero for any other address.
- R5: A write strobe whose address is on neither page changes no RAM word and no configuration word. A non-zero value in bits 14:11 puts an address on neither page.
- R6: The configuration page is the set of addresses with bits 10:8 = 3'b100 and bits 7:0 below 8. A first write strobe to such a word loads only its shadow. A write strobe to the same word that directly follows it also loads the active copy. Any other strobe in between cancels the pairing. Word k appears at `cfg_active_o[16k +: 16]`.
- R7: After each accepted strobe, `busy_o` is high for exactly 4 cycles.
- R8: A write to 0x0C, 0x14 or 0x15 while `busy_o` is high has no effect and sets `err_o`. `err_o` stays set until reset.
- R9: With hold mode off, writes to 0x15 cause no access and no lockout. `dp_coef_o` shows the RAM word at `dp_raddr_i` one cycle after that address is presented.
- R10: With hold mode on, `dp_coef_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Processor write enable |
| bus_addr_i | input | 8 | Direct register address |
| bus_wdata_i | input | 16 | Processor write data |
| rd_data_o | output | 16 | Result of the last indirect read |
| busy_o | output | 1 | Lockout after a strobe |
| err_o | output | 1 | Sticky flag for a write dropped while busy |
| hold_o | output | 1 | Hold mode; processor owns the RAM |
| dp_raddr_i | input | 8 | Datapath coefficient read address |
| dp_coef_o | output | 16 | Datapath coefficient read data |
| cfg_active_o | output | 128 | Active configuration words, 8 x 16 |

## Verification
Coefficient writes go to the first, last and a middle word. Each is read back, and a neighbouring word is read again to show that strobes land only at their own index. Writes to the unmapped page and to page 2 should leave existing words in place and read back as zero. This separates a correct page decode from one that only checks bit 9 or bit 8.

Configuration words are written once, written twice, and written in an interleaved pattern. These cases separate the shadow copy from the active copy.

Hold is cleared and set again with the datapath address moving. This shows who owns the port.

A write that lands during the lockout shows that the data register kept its old value, not the dropped one.

// File: rtl/coef_access_pkg.sv
package coef_access_pkg;
  localparam int unsigned DW = 16;
  localparam logic [7:0] REG_CTRL  = 8'h0C;
  localparam logic [7:0] REG_DATA  = 8'h14;
  localparam logic [7:0] REG_IADDR = 8'h15;
  localparam int unsigned HOLD_BIT = 12;

  typedef enum logic [1:0] {TGT_NONE, TGT_COEF, TGT_CFG} tgt_e;

  typedef struct packed {
    logic       is_read;
    tgt_e       tgt;
    logic [7:0] idx;
  } iaddr_dec_t;
endpackage

// File: rtl/cap_iaddr_decode.sv
module cap_iaddr_decode
  import coef_access_pkg::*;
#(
  parameter int unsigned CFG_NUM = 8
) (
  input  logic [15:0] iaddr_i,
  output iaddr_dec_t  dec_o
);
  always_comb begin
    dec_o.is_read = iaddr_i[15];
    dec_o.idx     = iaddr_i[7:0];
    dec_o.tgt     = TGT_NONE;
    if (iaddr_i[14:11] == 4'd0) begin
      if (iaddr_i[9:8] == 2'b11)
        dec_o.tgt = TGT_COEF;
      else if (iaddr_i[10:8] == 3'b100 && 32'(iaddr_i[7:0]) < CFG_NUM)
        dec_o.tgt = TGT_CFG;
    end
  end
endmodule

// File: rtl/cap_lockout.sv
module cap_lockout #(
  parameter int unsigned LOCK_CYC = 4,
  localparam int unsigned CW = $clog2(LOCK_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(LOCK_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/cap_coef_mem.sv
module cap_coef_mem #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          wr_i,
  input  logic [AW-1:0] cpu_idx_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic [AW-1:0] dp_raddr_i,
  output logic [DW-1:0] dp_rdata_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] port_addr;

  // single port: owner picked by hold mode
  assign port_addr   = hold_i ? cpu_idx_i : dp_raddr_i;
  assign cpu_rdata_o = mem[port_addr];

  always_ff @(posedge clk_i) begin
    if (hold_i && wr_i) mem[port_addr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dp_rdata_o <= '0;
    else if (!hold_i) dp_rdata_o <= mem[port_addr];
  end
endmodule

// File: rtl/cap_cfg_page.sv
module cap_cfg_page #(
  parameter int unsigned NUM = 8,
  parameter int unsigned DW  = 16,
  localparam int unsigned IW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              wr_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [NUM*DW-1:0] active_o
);
  logic [DW-1:0] shadow_q [NUM];
  logic          arm_q;
  logic [IW-1:0] arm_idx_q;
  logic          promote;

  assign promote   = wr_i && arm_q && (arm_idx_q == idx_i);
  assign rd_data_o = shadow_q[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q     <= 1'b0;
      arm_idx_q <= '0;
    end else if (stb_i) begin
      arm_q     <= wr_i && !promote;
      arm_idx_q <= idx_i;
    end
  end

  for (genvar g = 0; g < NUM; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[g]          <= '0;
        active_o[g*DW +: DW] <= '0;
      end else if (idx_i == IW'(g)) begin
        if (wr_i)    shadow_q[g]          <= wr_data_i;
        if (promote) active_o[g*DW +: DW] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/coef_access_port.sv
module coef_access_port
  import coef_access_pkg::*;
#(
  parameter int unsigned COEF_DEPTH = 256,
  parameter int unsigned CFG_NUM    = 8,
  parameter int unsigned LOCK_CYC   = 4,
  localparam int unsigned COEF_AW   = $clog2(COEF_DEPTH),
  localparam int unsigned CFG_IW    = (CFG_NUM > 1) ? $clog2(CFG_NUM) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_we_i,
  input  logic [7:0]            bus_addr_i,
  input  logic [DW-1:0]         bus_wdata_i,
  output logic [DW-1:0]         rd_data_o,
  output logic                  busy_o,
  output logic                  err_o,
  output logic                  hold_o,
  input  logic [COEF_AW-1:0]    dp_raddr_i,
  output logic [DW-1:0]         dp_coef_o,
  output logic [CFG_NUM*DW-1:0] cfg_active_o
);
  logic          hit_reg, accept, stb;
  logic [DW-1:0] data_q, coef_rdata, cfg_rdata;
  iaddr_dec_t    dec;

  assign hit_reg = bus_we_i && (bus_addr_i == REG_CTRL || bus_addr_i == REG_DATA ||
                                bus_addr_i == REG_IADDR);
  assign accept  = hit_reg && !busy_o;
  assign stb     = accept && hold_o && (bus_addr_i == REG_IADDR);

  cap_iaddr_decode #(.CFG_NUM(CFG_NUM)) u_dec (
    .iaddr_i (bus_wdata_i),
    .dec_o   (dec)
  );

  cap_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (stb),
    .busy_o  (busy_o)
  );

  cap_coef_mem #(.DEPTH(COEF_DEPTH), .DW(DW)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_i      (hold_o),
    .wr_i        (stb && !dec.is_read && dec.tgt == TGT_COEF),
    .cpu_idx_i   (dec.idx[COEF_AW-1:0]),
    .wr_data_i   (data_q),
    .cpu_rdata_o (coef_rdata),
    .dp_raddr_i  (dp_raddr_i),
    .dp_rdata_o  (dp_coef_o)
  );

  cap_cfg_page #(.NUM(CFG_NUM), .DW(DW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (stb),
    .wr_i      (stb && !dec.is_read && dec.tgt == TGT_CFG),
    .idx_i     (dec.idx[CFG_IW-1:0]),
    .wr_data_i (data_q),
    .rd_data_o (cfg_rdata),
    .active_o  (cfg_active_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o    <= 1'b0;
      data_q    <= '0;
      err_o     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      if (hit_reg && busy_o) err_o <= 1'b1;
      if (accept && bus_addr_i == REG_CTRL) hold_o <= bus_wdata_i[HOLD_BIT];
      if (accept && bus_addr_i == REG_DATA) data_q <= bus_wdata_i;
      if (stb && dec.is_read) begin
        unique case (dec.tgt)
          TGT_COEF: rd_data_o <= coef_rdata;
          TGT_CFG:  rd_data_o <= cfg_rdata;
          default:  rd_data_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/coef_access_port_chk.sv
module coef_access_port_chk #(
  parameter int unsigned LOCK_CYC = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_we_i,
  input logic [7:0]  bus_addr_i,
  input logic [15:0] bus_wdata_i,
  input logic [15:0] rd_data_o,
  input logic        busy_o,
  input logic        err_o,
  input logic        hold_o,
  input logic [15:0] dp_coef_o
);
  logic [31:0] run_q;
  logic        reg_wr;

  assign reg_wr = bus_we_i && (bus_addr_i == 8'h0C || bus_addr_i == 8'h14 ||
                               bus_addr_i == 8'h15);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  a_r7_busy_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == LOCK_CYC));

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  a_r8_busy_write_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr && busy_o) |=> err_o);

  a_r9_no_strobe_without_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && !busy_o && bus_we_i && bus_addr_i == 8'h15) |=> !busy_o);

  a_r10_dp_frozen_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> $stable(dp_coef_o));

  a_r4_rdata_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_data_o) |-> $past(bus_we_i && bus_addr_i == 8'h15 && bus_wdata_i[15] &&
                                  hold_o && !busy_o));
endmodule

bind coef_access_port coef_access_port_chk #(.LOCK_CYC(LOCK_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .rd_data_o   (rd_data_o),
  .busy_o      (busy_o),
  .err_o       (err_o),
  .hold_o      (hold_o),
  .dp_coef_o   (dp_coef_o)
);

// File: tb/coef_access_port_bench.sv
`timescale 1ns/1ps
module coef_access_port_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [15:0]  wdata = '0;
  logic [7:0]   dp_raddr = '0;
  logic [15:0]  rd_data, dp_coef;
  logic         busy, err, hold;
  logic [127:0] cfg_active;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  coef_access_port u_coef_access_port (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bus_we_i     (we),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .rd_data_o    (rd_data),
    .busy_o       (busy),
    .err_o        (err),
    .hold_o       (hold),
    .dp_raddr_i   (dp_raddr),
    .dp_coef_o    (dp_coef),
    .cfg_active_o (cfg_active)
  );

  // {write address, data, read address, expected read}
  localparam logic [63:0] VEC [6] = '{
    {16'h0300, 16'h1234, 16'h8300, 16'h1234},
    {16'h03FF, 16'h8001, 16'h83FF, 16'h8001},
    {16'h0355, 16'h7FFF, 16'h8300, 16'h1234},
    {16'h0100, 16'hBEEF, 16'h8100, 16'h0000},
    {16'h0403, 16'h00A5, 16'h8403, 16'h00A5},
    {16'h0200, 16'h5555, 16'h8355, 16'h7FFF}
  };

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic access(logic [15:0] iaddr);
    bus_wr(8'h15, iaddr);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 16'(busy), 16'h0);
    check("R1 err", 16'(err), 16'h0);
    check("R1 hold", 16'(hold), 16'h0);
    check("R1 rd_data", rd_data, 16'h0);
    check("R1 dp_coef", dp_coef, 16'h0);
    check("R1 cfg_active", 16'(cfg_active != '0), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    bus_wr(8'h0C, 16'h1000);
    check("R2 hold on", 16'(hold), 16'h1);

    // lockout length (R7)
    bus_wr(8'h14, 16'h1234);
    check("R7 no busy after data write", 16'(busy), 16'h0);
    bus_wr(8'h15, 16'h0300);
    check("R7 busy cycle 1", 16'(busy), 16'h1);
    repeat (3) @(negedge clk);
    check("R7 busy cycle 4", 16'(busy), 16'h1);
    @(negedge clk);
    check("R7 busy clear", 16'(busy), 16'h0);

    // table walk (R3 R4 R5 R6 shadow)
    for (int i = 0; i < 6; i++) begin
      bus_wr(8'h14, VEC[i][47:32]);
      access(VEC[i][63:48]);
      access(VEC[i][31:16]);
      check($sformatf("R3/R4/R5 vector %0d", i), rd_data, VEC[i][15:0]);
    end
    access(16'h8900);
    check("R5 reserved bits read zero", rd_data, 16'h0000);
    check("R6 single write leaves active", cfg_active[3*16 +: 16], 16'h0000);

    // second strobe promotes (R6)
    bus_wr(8'h14, 16'h00C3);
    access(16'h0405);
    check("R6 first strobe shadow only", cfg_active[5*16 +: 16], 16'h0000);
    access(16'h0405);
    check("R6 second strobe active", cfg_active[5*16 +: 16], 16'h00C3);
    bus_wr(8'h14, 16'h0077);
    access(16'h0406);
    access(16'h0407);
    access(16'h0406);
    check("R6 interleaved no promote", cfg_active[6*16 +: 16], 16'h0000);
    access(16'h8406);
    check("R6 shadow readback", rd_data, 16'h0077);

    // hold off: datapath owns RAM (R9)
    bus_wr(8'h0C, 16'h0000);
    check("R2 hold off", 16'(hold), 16'h0);
    dp_raddr = 8'h00;
    @(negedge clk);
    check("R9 dp read word 0", dp_coef, 16'h1234);
    dp_raddr = 8'h55;
    @(negedge clk);
    check("R9 dp read word 55", dp_coef, 16'h7FFF);
    bus_wr(8'h14, 16'h9999);
    bus_wr(8'h15, 16'h0300);
    check("R9 no lockout without hold", 16'(busy), 16'h0);
    dp_raddr = 8'h00;
    @(negedge clk);
    check("R9 strobe ignored", dp_coef, 16'h1234);
    dp_raddr = 8'hFF;
    @(negedge clk);
    check("R9 dp read word FF", dp_coef, 16'h8001);

    // hold on freezes datapath output (R10)
    bus_wr(8'h0C, 16'h1000);
    dp_raddr = 8'h00;
    repeat (2) @(negedge clk);
    check("R10 dp frozen", dp_coef, 16'h8001);
    check("R8 no error yet", 16'(err), 16'h0);

    // write while busy (R8)
    bus_wr(8'h14, 16'h1111);
    bus_wr(8'h15, 16'h0311);
    bus_wr(8'h14, 16'h2222);
    check("R8 err set", 16'(err), 16'h1);
    idle();
    access(16'h0312);
    access(16'h8312);
    check("R8 dropped data write", rd_data, 16'h1111);
    check("R8 err sticky", 16'(err), 16'h1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule